// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulation Flag Generator

This block rebuilds the three interrupt sources of a legacy real-time clock (once-per-second update, time-of-day alarm and programmable periodic) out of a single free-running counter and one equality comparator. A base tick runs at 64 Hz. The comparator is armed at the counter value plus a tick delta, and every time the counter reaches it, the comparator is moved forward. The tick is then evaluated against the enabled sources. If at least one source qualifies, the block produces a one-cycle interrupt pulse and a flag word. Software can read the flag word just as it would read the old clock's flag register.

The comparator only detects equality, so a tick can be missed when the counter has already moved past the next target. After a match, the block therefore keeps stepping the comparator by the delta, one step per clock, until a wrap-safe signed test shows that the comparator is ahead of the counter. Each step beyond the first counts as a lost tick, and lost ticks are credited to the periodic divider. Periodic rates at or below 64 Hz are divided down from the base tick. Faster rates shrink the tick delta itself.

Top module: `rtcemu_flag_gen`

## Requirements
- R1: While reset is asserted and afterwards until an enable is set, `irq_o` is low and `flags_o` is zero.
- R2: When any enable is set while the channel is off, the comparator is loaded with the counter value of that cycle plus the delta. The pulse for a tick appears in the second cycle after the cycle in which the counter equals the comparator. Without catch-up, the next tick follows exactly one delta of counter values later.
- R3: After a match, the comparator advances by the delta once per cycle until the signed 32-bit value (counter minus comparator) is negative. Each advance beyond the first is one lost tick, and lost ticks are added to the periodic divide count when the periodic source is enabled.
- R4: Rate code k selects 2^k Hz. Codes below 1 are treated as 1 and codes above 13 as 13. The delta is BASE_DELTA unless periodic is enabled with k above 6, in which case it is BASE_DELTA >> (k-6).
- R5: For k at or below 6, a periodic flag is raised when the divide count, plus one for the tick, plus lost ticks, reaches 2^(6-k). The count is then cleared. It is also cleared while periodic is disabled.
- R6: For k above 6, every tick raises the periodic flag.
- R7: On a tick, the update flag is raised when the current seconds differ from the seconds stored at the previous tick. The first tick after update is enabled never raises it.
- R8: On a tick, the alarm flag is raised when hour, minute and second all equal the alarm inputs.
- R9: The flag word has update at bit 4, alarm at bit 5, periodic at bit 6 and pending at bit 7, and the value 1 in bits 15:8. It is driven together with a one-cycle `irq_o` only when a flag is set, and is zero otherwise.
- R10: With all three enables low, the channel is off and no pulse is produced until an enable is set again.
- R11: Arming, matching and catch-up work across the wrap of the 32-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Update source enable |
| alm_en_i | input | 1 | Alarm source enable |
| per_en_i | input | 1 | Periodic source enable |
| alm_hour_i | input | 5 | Alarm hour |
| alm_min_i | input | 6 | Alarm minute |
| alm_sec_i | input | 6 | Alarm second |
| rate_code_i | input | CODE_W | Periodic rate code k, rate 2^k Hz |
| count_i | input | CNT_W | Free-running counter value |
| now_hour_i | input | 5 | Current hour |
| now_min_i | input | 6 | Current minute |
| now_sec_i | input | 6 | Current second |
| flags_o | output | 16 | Flag word, valid with irq_o |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the counter passes through the comparator value one count at a time, so that a match is seen, and that it jumps only while the block is stepping. The stimulus advances the counter by one per cycle. It makes its one forward jump during the stepping phase and places its wrap test while the channel is off. The rate and delta assertions take the delta to be non-zero, which holds because BASE_DELTA is at least 2^7. Clamped rate codes are driven only for the one boundary test. The time inputs change only away from the cycles in which ticks are evaluated.

// File: rtl/rtcemu_pkg.sv
package rtcemu_pkg;

    localparam int HOUR_W = 5;
    localparam int MIN_W  = 6;
    localparam int SEC_W  = 6;

    localparam int WORD_W        = 16;
    localparam int FLAG_UPD_BIT  = 4;
    localparam int FLAG_ALM_BIT  = 5;
    localparam int FLAG_PER_BIT  = 6;
    localparam int FLAG_PEND_BIT = 7;
    localparam int FLAG_CNT_LSB  = 8;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_STEP = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } wall_time_t;

endpackage

// File: rtl/rtcemu_rate_sel.sv
module rtcemu_rate_sel #(
    parameter int CNT_W      = 32,
    parameter int CODE_W     = 4,
    parameter int BASE_DELTA = 1024,
    parameter int BASE_LOG2  = 6,
    parameter int MAX_CODE   = 13,
    parameter int LIM_W      = BASE_LOG2 + 1
) (
    input  logic              per_en_i,
    input  logic [CODE_W-1:0] rate_code_i,
    output logic [CNT_W-1:0]  delta_o,
    output logic              fast_o,
    output logic [LIM_W-1:0]  limit_o
);

    logic [CODE_W-1:0] code_c;

    // Clamp the rate code, then derive the tick delta and the divide limit
    always_comb begin
        code_c = rate_code_i;
        if (rate_code_i < CODE_W'(1)) begin
            code_c = CODE_W'(1);
        end else if (rate_code_i > CODE_W'(MAX_CODE)) begin
            code_c = CODE_W'(MAX_CODE);
        end

        fast_o  = per_en_i && (code_c > CODE_W'(BASE_LOG2));
        delta_o = CNT_W'(BASE_DELTA);
        if (fast_o) begin
            delta_o = CNT_W'(BASE_DELTA) >> (code_c - CODE_W'(BASE_LOG2));
        end

        limit_o = LIM_W'(1);
        if (code_c <= CODE_W'(BASE_LOG2)) begin
            limit_o = LIM_W'(1) << (CODE_W'(BASE_LOG2) - code_c);
        end
    end

endmodule

// File: rtl/rtcemu_tick_seq.sv
module rtcemu_tick_seq
    import rtcemu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_en_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  delta_i,
    output logic              tick_o,
    output logic [LOST_W-1:0] lost_o,
    output seq_state_e        state_o,
    output logic [CNT_W-1:0]  cmp_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cmp;
        logic [LOST_W-1:0] lost;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic [CNT_W-1:0] gap;

    always_comb begin
        seq_d  = seq_q;
        tick_o = 1'b0;
        gap    = count_i - seq_q.cmp;

        if (!any_en_i) begin
            seq_d.st = SEQ_OFF;
        end else begin
            case (seq_q.st)
                SEQ_OFF: begin
                    seq_d.cmp = count_i + delta_i;
                    seq_d.st  = SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (count_i == seq_q.cmp) begin
                        seq_d.cmp  = seq_q.cmp + delta_i;
                        seq_d.lost = '0;
                        seq_d.st   = SEQ_STEP;
                    end
                end
                SEQ_STEP: begin
                    // comparator ahead when counter minus comparator is negative
                    if (gap[CNT_W-1]) begin
                        tick_o   = 1'b1;
                        seq_d.st = SEQ_WAIT;
                    end else begin
                        seq_d.cmp = seq_q.cmp + delta_i;
                        if (seq_q.lost != '1) begin
                            seq_d.lost = seq_q.lost + LOST_W'(1);
                        end
                    end
                end
                default: seq_d.st = SEQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= SEQ_OFF;
            seq_q.cmp  <= '0;
            seq_q.lost <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign lost_o  = seq_q.lost;
    assign state_o = seq_q.st;
    assign cmp_o   = seq_q.cmp;

endmodule

// File: rtl/rtcemu_src_eval.sv
module rtcemu_src_eval
    import rtcemu_pkg::*;
#(
    parameter int LOST_W = 8,
    parameter int LIM_W  = 7,
    parameter int SUM_W  = ((LOST_W > LIM_W) ? LOST_W : LIM_W) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [LOST_W-1:0] lost_i,
    input  logic              upd_en_i,
    input  logic              alm_en_i,
    input  logic              per_en_i,
    input  logic              fast_i,
    input  logic [LIM_W-1:0]  limit_i,
    input  wall_time_t        now_i,
    input  wall_time_t        alarm_i,
    output logic [WORD_W-1:0] flags_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [SEC_W-1:0]  prev_sec;
        logic              prev_ok;
        logic [SUM_W-1:0]  pie;
        logic [WORD_W-1:0] flags;
        logic              irq;
    } eval_regs_t;

    eval_regs_t ev_d, ev_q;
    logic [SUM_W-1:0] pie_sum;
    logic upd_hit, alm_hit, per_hit;

    always_comb begin
        ev_d       = ev_q;
        ev_d.flags = '0;
        ev_d.irq   = 1'b0;
        upd_hit    = 1'b0;
        alm_hit    = 1'b0;
        per_hit    = 1'b0;
        pie_sum    = ev_q.pie + SUM_W'(1) + SUM_W'(lost_i);

        if (tick_i) begin
            upd_hit = upd_en_i && ev_q.prev_ok && (now_i.sec != ev_q.prev_sec);
            alm_hit = alm_en_i && (now_i == alarm_i);
            if (per_en_i) begin
                if (fast_i) begin
                    per_hit = 1'b1;
                end else if (pie_sum >= SUM_W'(limit_i)) begin
                    per_hit  = 1'b1;
                    ev_d.pie = '0;
                end else begin
                    ev_d.pie = pie_sum;
                end
            end
            if (upd_en_i) begin
                ev_d.prev_sec = now_i.sec;
                ev_d.prev_ok  = 1'b1;
            end
        end

        if (!upd_en_i) begin
            ev_d.prev_ok = 1'b0;
        end
        if (!per_en_i) begin
            ev_d.pie = '0;
        end

        if (upd_hit || alm_hit || per_hit) begin
            ev_d.irq                        = 1'b1;
            ev_d.flags[FLAG_UPD_BIT]        = upd_hit;
            ev_d.flags[FLAG_ALM_BIT]        = alm_hit;
            ev_d.flags[FLAG_PER_BIT]        = per_hit;
            ev_d.flags[FLAG_PEND_BIT]       = 1'b1;
            ev_d.flags[WORD_W-1:FLAG_CNT_LSB] = (WORD_W-FLAG_CNT_LSB)'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q.prev_sec <= '0;
            ev_q.prev_ok  <= 1'b0;
            ev_q.pie      <= '0;
            ev_q.flags    <= '0;
            ev_q.irq      <= 1'b0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign flags_o = ev_q.flags;
    assign irq_o   = ev_q.irq;

endmodule

// File: rtl/rtcemu_flag_gen.sv
module rtcemu_flag_gen
    import rtcemu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int CODE_W     = 4,
    parameter int BASE_DELTA = 1024,
    parameter int BASE_LOG2  = 6,
    parameter int MAX_CODE   = 13,
    parameter int LOST_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en_i,
    input  logic              alm_en_i,
    input  logic              per_en_i,
    input  logic [HOUR_W-1:0] alm_hour_i,
    input  logic [MIN_W-1:0]  alm_min_i,
    input  logic [SEC_W-1:0]  alm_sec_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [HOUR_W-1:0] now_hour_i,
    input  logic [MIN_W-1:0]  now_min_i,
    input  logic [SEC_W-1:0]  now_sec_i,
    output logic [WORD_W-1:0] flags_o,
    output logic              irq_o
);

    localparam int LIM_W = BASE_LOG2 + 1;

    logic              any_en;
    logic [CNT_W-1:0]  step_delta;
    logic              fast_rate;
    logic [LIM_W-1:0]  div_limit;
    logic              seq_tick;
    logic [LOST_W-1:0] seq_lost;
    seq_state_e        seq_st;
    logic [CNT_W-1:0]  seq_cmp;
    wall_time_t        now_t, alarm_t;

    assign any_en  = upd_en_i | alm_en_i | per_en_i;
    assign now_t   = '{hour: now_hour_i, min: now_min_i, sec: now_sec_i};
    assign alarm_t = '{hour: alm_hour_i, min: alm_min_i, sec: alm_sec_i};

    rtcemu_rate_sel #(
        .CNT_W(CNT_W), .CODE_W(CODE_W), .BASE_DELTA(BASE_DELTA),
        .BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE), .LIM_W(LIM_W)
    ) u_rate (
        .per_en_i    (per_en_i),
        .rate_code_i (rate_code_i),
        .delta_o     (step_delta),
        .fast_o      (fast_rate),
        .limit_o     (div_limit)
    );

    rtcemu_tick_seq #(
        .CNT_W(CNT_W), .LOST_W(LOST_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_en_i (any_en),
        .count_i  (count_i),
        .delta_i  (step_delta),
        .tick_o   (seq_tick),
        .lost_o   (seq_lost),
        .state_o  (seq_st),
        .cmp_o    (seq_cmp)
    );

    rtcemu_src_eval #(
        .LOST_W(LOST_W), .LIM_W(LIM_W)
    ) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (seq_tick),
        .lost_i   (seq_lost),
        .upd_en_i (upd_en_i),
        .alm_en_i (alm_en_i),
        .per_en_i (per_en_i),
        .fast_i   (fast_rate),
        .limit_i  (div_limit),
        .now_i    (now_t),
        .alarm_i  (alarm_t),
        .flags_o  (flags_o),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/rtcemu_chk.sv
module rtcemu_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             any_en,
    input logic             irq,
    input logic [15:0]      flags,
    input logic [1:0]       st,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] delta,
    input logic             tick
);

    // R9
    irq_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags[15:8] == 8'd1) && flags[7]);

    // R9
    quiet_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (flags == 16'd0));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> !irq);

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd2 && !tick && any_en) |=> (cmp == $past(cmp) + $past(delta)));

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd1 && any_en && count != cmp) |=> (cmp == $past(cmp)));

endmodule

bind rtcemu_flag_gen rtcemu_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .any_en (any_en),
    .irq    (irq_o),
    .flags  (flags_o),
    .st     (seq_st),
    .cmp    (seq_cmp),
    .count  (count_i),
    .delta  (step_delta),
    .tick   (seq_tick)
);

// File: tb/rtcemu_flag_gen_tb.sv
`timescale 1ns/1ps
module rtcemu_flag_gen_tb_top;

    localparam int BD = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        upd_en = 0, alm_en = 0, per_en = 0;
    logic [4:0]  ah = 0, nh = 0;
    logic [5:0]  am = 0, as_ = 0, nm = 0, ns = 0;
    logic [3:0]  code = 4'd6;
    logic [31:0] cnt = 32'h0000_1000;
    logic [15:0] flags;
    logic        irq;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    rtcemu_flag_gen #(.BASE_DELTA(BD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .upd_en_i(upd_en), .alm_en_i(alm_en), .per_en_i(per_en),
        .alm_hour_i(ah), .alm_min_i(am), .alm_sec_i(as_),
        .rate_code_i(code), .count_i(cnt),
        .now_hour_i(nh), .now_min_i(nm), .now_sec_i(ns),
        .flags_o(flags), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_mode = 0;     // 0 off, 1 waiting, 2 stepping
    logic [31:0] m_cmp  = 0;
    int          m_lost = 0;
    logic [5:0]  m_psec = 0;
    bit          m_pok  = 0;
    int          m_pie  = 0;
    logic [15:0] e_flags = 0;
    bit          e_irq   = 0;
    bit          mt, muf, maf, mpf, mfast, many;
    int          mk, mlim, msum;
    logic [31:0] md, mdiff;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cmp = 0; m_lost = 0; m_psec = 0; m_pok = 0; m_pie = 0;
            e_flags = 0; e_irq = 0;
        end else begin
            many = upd_en | alm_en | per_en;
            mk = int'(code);
            if (mk < 1) mk = 1;
            if (mk > 13) mk = 13;
            mfast = per_en && (mk > 6);
            md = BD;
            if (mfast) for (int i = 6; i < mk; i++) md = md / 2;
            mlim = 1;
            for (int i = mk; i < 6; i++) mlim = mlim * 2;
            mt = 0;
            if (!many) m_mode = 0;
            else if (m_mode == 0) begin m_cmp = cnt + md; m_mode = 1; end
            else if (m_mode == 1) begin
                if (cnt == m_cmp) begin m_cmp = m_cmp + md; m_lost = 0; m_mode = 2; end
            end else begin
                mdiff = cnt - m_cmp;
                if (mdiff[31]) begin mt = 1; m_mode = 1; end
                else begin m_cmp = m_cmp + md; if (m_lost < 255) m_lost++; end
            end
            muf = 0; maf = 0; mpf = 0;
            if (mt) begin
                muf = upd_en && m_pok && (ns != m_psec);
                maf = alm_en && nh == ah && nm == am && ns == as_;
                if (per_en) begin
                    if (mfast) mpf = 1;
                    else begin
                        msum = m_pie + 1 + m_lost;
                        if (msum >= mlim) begin mpf = 1; m_pie = 0; end
                        else m_pie = msum;
                    end
                end
                if (upd_en) begin m_psec = ns; m_pok = 1; end
            end
            if (!upd_en) m_pok = 0;
            if (!per_en) m_pie = 0;
            e_irq = muf | maf | mpf;
            e_flags = 0;
            if (e_irq) e_flags = 16'h0180 | (muf ? 16'h10 : 16'h0) |
                                 (maf ? 16'h20 : 16'h0) | (mpf ? 16'h40 : 16'h0);
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic cyc();
        logic [15:0] dx;
        string tag;
        @(negedge clk);
        n_checks++;
        if (flags !== e_flags || irq !== e_irq) begin
            dx = flags ^ e_flags;
            if (dx[4]) tag = "R7";
            else if (dx[5]) tag = "R8";
            else if (dx[6]) tag = "R5/R6";
            else tag = "R9";
            n_err++;
            $display("FAIL %s at %0t flags 0x%h irq %b expected flags 0x%h irq %b",
                     tag, $time, flags, irq, e_flags, e_irq);
        end
        cnt = cnt + 1;
    endtask

    task automatic wait_pulse(input int maxc, output int n, output logic [15:0] w);
        n = -1; w = 0;
        for (int i = 1; i <= maxc; i++) begin
            cyc();
            if (irq === 1'b1) begin n = i; w = flags; break; end
        end
    endtask

    task automatic count_pulses(input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            cyc();
            if (irq === 1'b1) c++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    // ---------------- stimulus ----------------
    int n, c;
    logic [15:0] w;

    initial begin
        rst_n = 1'b0;
        repeat (4) cyc();
        // R1: reset state
        chk(flags == 0 && irq == 0, "R1", int'(flags), 0);
        rst_n = 1'b1;
        count_pulses(40, c);
        chk(c == 0, "R1", c, 0);

        // R2 / R8 / R9: alarm matching current time
        nh = 5'd3; nm = 6'd4; ns = 6'd12;
        ah = 5'd3; am = 6'd4; as_ = 6'd12;
        alm_en = 1;
        wait_pulse(400, n, w);
        chk(n == 258, "R2", n, 258);
        chk(w == 16'h01A0, "R8", int'(w), 'h1A0);
        chk(w[15:8] == 8'd1 && w[7], "R9", int'(w), 'h1A0);
        wait_pulse(400, n, w);
        chk(n == 256, "R2", n, 256);
        as_ = 6'd13;
        count_pulses(600, c);
        chk(c == 0, "R8", c, 0);
        alm_en = 0;
        repeat (3) cyc();

        // R7: update flag, first tick suppressed
        ns = 6'd20; upd_en = 1;
        c = 0;
        for (int i = 0; i < 300; i++) begin
            if (i == 100) ns = 6'd21;
            cyc();
            if (irq === 1'b1) c++;
        end
        chk(c == 0, "R7", c, 0);
        ns = 6'd22;
        wait_pulse(400, n, w);
        chk(w == 16'h0190, "R7", int'(w), 'h190);
        count_pulses(250, c);
        chk(c == 0, "R7", c, 0);
        upd_en = 0;
        repeat (3) cyc();

        // R5: slow periodic, code 5 divides by 2
        code = 4'd5; per_en = 1;
        wait_pulse(800, n, w);
        chk(n == 514, "R5", n, 514);
        chk(w == 16'h01C0, "R5", int'(w), 'h1C0);
        wait_pulse(800, n, w);
        chk(n == 512, "R5", n, 512);
        code = 4'd6;
        wait_pulse(400, n, w);
        chk(n == 256, "R5", n, 256);

        // R6 / R4: fast rates shrink the delta
        code = 4'd8;
        wait_pulse(400, n, w);
        chk(n == 256, "R4", n, 256);
        wait_pulse(400, n, w);
        chk(n == 64, "R6", n, 64);
        chk(w == 16'h01C0, "R6", int'(w), 'h1C0);
        code = 4'd15;
        wait_pulse(100, n, w);
        chk(n == 64, "R4", n, 64);
        wait_pulse(100, n, w);
        chk(n == 2, "R4", n, 2);

        // R10: all enables low
        per_en = 0;
        count_pulses(800, c);
        chk(c == 0, "R10", c, 0);

        // R3: lost ticks credited to the divider (code 3 divides by 8)
        code = 4'd3; per_en = 1;
        wait_pulse(2200, n, w);
        chk(n == 2050, "R5", n, 2050);
        for (int i = 0; i < 400; i++) begin
            cyc();
            if (m_mode == 2) break;
        end
        cnt = cnt + 32'd768;
        wait_pulse(2000, n, w);
        chk(n == 1025, "R3", n, 1025);
        per_en = 0;
        repeat (3) cyc();

        // R11: arming across the counter wrap
        cnt = 32'hFFFF_FFC0;
        as_ = ns; alm_en = 1;
        wait_pulse(400, n, w);
        chk(n == 258, "R11", n, 258);
        chk(w == 16'h01A0, "R11", int'(w), 'h1A0);
        wait_pulse(400, n, w);
        chk(n == 256, "R11", n, 256);
        alm_en = 0;
        repeat (5) cyc();

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule